// File: doc/BRIEF.md
# Multi-core idle state coordinator

The coordinator turns the idle state that each core of a small multi-core processor asks for into the state that core is actually granted. It then drives the per-core power controls from that grant: pipeline stop, full clock gating and reduced supply voltage. It also drives one enable that lets the shared non-core logic power down. Each request is a 3-bit state code. The grants are registered, so a grant takes effect one clock after its request.

A mode input tells the block how the cores are supplied. When they share one supply plane, the voltage can drop only if every core can tolerate it. An active core therefore limits all idle cores to the clock-stopped state. When a core wakes, the other cores leave any voltage-lowered state on that same clock edge. When each core has its own plane, every core is granted exactly what it asks for. The mode can change only at a point where no core could be caught in a deep state by the change, which is when every granted state is active.

Top module: `idle_state_coord`

## Requirements
- R1: State codes are 0 (active) up to 6 (deepest), and a larger code is a deeper state. A request code of 7 is handled exactly like 6.
- R2: In shared mode, when every core requests a nonzero code, each grant equals that core's own request after the next rising clock edge.
- R3: In shared mode, when at least one core requests 0, each idle core's grant is its request limited to at most 3.
- R4: A core requesting 0 is granted 0 after the next rising edge, in either mode. In shared mode, the other cores' grants fall to 3 or less on that same edge.
- R5: In independent mode, each grant equals that core's own request, up to 6, whatever the other cores request.
- R6: `uncore_pd_o` is 1 exactly when every core's grant is 6.
- R7: For each core, `pipe_stop_o` is 1 when its grant is 1 or more, `clk_gate_o` is 1 when its grant is 3 or more, and `volt_low_o` is 1 when its grant is 4 or more.
- R8: While `rst_ni` is low, every grant is 0, every control output is 0 and `uncore_pd_o` is 0.
- R9: `shared_mode_i` (1 = shared plane, 0 = independent planes) is taken in only at a rising edge where every current grant is 0, and it already governs the grants formed at that edge. At any other edge it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_mode_i | input | 1 | 1 = all cores on one plane, 0 = each core on its own plane |
| req_i | input | NUM_CORES x 3 | Requested state code for each core |
| grant_o | output | NUM_CORES x 3 | Granted state code for each core |
| pipe_stop_o | output | NUM_CORES | Per-core pipeline stop |
| clk_gate_o | output | NUM_CORES | Per-core full clock gate |
| volt_low_o | output | NUM_CORES | Per-core reduced supply voltage |
| uncore_pd_o | output | 1 | Non-core logic may power down |

## Verification
The assertions take for granted that every request is held stable across each rising edge and is never unknown. They also take for granted that the mode input is a clean level, because the mode-hold check watches only the stored mode. No assumption is needed about the order or depth of requests, since any pattern of codes 0 to 7 is legal. The stimulus drives requests and mode only on falling edges. It mixes directed sequences with random codes that include 7, and it forces all cores to 0 at intervals so that the mode can switch and be tried both ways.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;
  localparam int unsigned STATE_W = 3;
  typedef logic [STATE_W-1:0] cstate_t;

  localparam cstate_t ST_ACTIVE   = 3'd0;
  localparam cstate_t ST_PIPE_MIN = 3'd1;
  localparam cstate_t ST_CLK_MIN  = 3'd3;
  localparam cstate_t ST_VOLT_MIN = 3'd4;
  localparam cstate_t ST_DEEPEST  = 3'd6;
  // deepest state allowed while another core on a shared plane is running
  localparam cstate_t ST_SHARED_CAP = ST_CLK_MIN;

  function automatic cstate_t clamp_state(cstate_t s);
    return (s > ST_DEEPEST) ? ST_DEEPEST : s;
  endfunction
endpackage

// File: rtl/idle_req_resolve.sv
module idle_req_resolve
  import idle_coord_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                                shared_i,
  input  logic [NUM_CORES-1:0][STATE_W-1:0]   req_i,
  output logic [NUM_CORES-1:0][STATE_W-1:0]   grant_d_o
);
  cstate_t [NUM_CORES-1:0] clamped;
  logic                    any_active;

  always_comb begin
    any_active = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      clamped[i] = clamp_state(req_i[i]);
      if (clamped[i] == ST_ACTIVE) any_active = 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      always_comb begin
        if (shared_i && any_active && (clamped[g] > ST_SHARED_CAP))
          grant_d_o[g] = ST_SHARED_CAP;
        else
          grant_d_o[g] = clamped[g];
      end
    end
  endgenerate
endmodule

// File: rtl/core_power_decode.sv
module core_power_decode
  import idle_coord_pkg::*;
(
  input  logic [STATE_W-1:0] grant_i,
  output logic               pipe_stop_o,
  output logic               clk_gate_o,
  output logic               volt_low_o
);
  assign pipe_stop_o = (grant_i >= ST_PIPE_MIN);
  assign clk_gate_o  = (grant_i >= ST_CLK_MIN);
  assign volt_low_o  = (grant_i >= ST_VOLT_MIN);
endmodule

// File: rtl/idle_state_coord.sv
module idle_state_coord
  import idle_coord_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              shared_mode_i,
  input  logic [NUM_CORES-1:0][STATE_W-1:0] req_i,
  output logic [NUM_CORES-1:0][STATE_W-1:0] grant_o,
  output logic [NUM_CORES-1:0]              pipe_stop_o,
  output logic [NUM_CORES-1:0]              clk_gate_o,
  output logic [NUM_CORES-1:0]              volt_low_o,
  output logic                              uncore_pd_o
);
  logic [NUM_CORES-1:0][STATE_W-1:0] grant_q, grant_d;
  logic mode_q, mode_d;
  logic all_c0, all_deep;

  always_comb begin
    all_c0   = 1'b1;
    all_deep = 1'b1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (grant_q[i] != ST_ACTIVE)  all_c0   = 1'b0;
      if (grant_q[i] != ST_DEEPEST) all_deep = 1'b0;
    end
  end

  // mode only moves while nothing is asleep
  assign mode_d = all_c0 ? shared_mode_i : mode_q;

  idle_req_resolve #(.NUM_CORES(NUM_CORES)) u_resolve (
    .shared_i  (mode_d),
    .req_i     (req_i),
    .grant_d_o (grant_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      mode_q  <= 1'b1;
    end else begin
      grant_q <= grant_d;
      mode_q  <= mode_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_dec
      core_power_decode u_dec (
        .grant_i     (grant_q[g]),
        .pipe_stop_o (pipe_stop_o[g]),
        .clk_gate_o  (clk_gate_o[g]),
        .volt_low_o  (volt_low_o[g])
      );
    end
  endgenerate

  assign grant_o     = grant_q;
  assign uncore_pd_o = all_deep;
endmodule

// File: rtl/idle_state_coord_chk.sv
module idle_state_coord_chk
  import idle_coord_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_CORES-1:0][STATE_W-1:0] req_i,
  input logic [NUM_CORES-1:0][STATE_W-1:0] grant_o,
  input logic [NUM_CORES-1:0]              pipe_stop_o,
  input logic [NUM_CORES-1:0]              clk_gate_o,
  input logic [NUM_CORES-1:0]              volt_low_o,
  input logic                              uncore_pd_o,
  input logic                              mode_q,
  input logic                              all_c0
);
  logic any_run, any_low;
  always_comb begin
    any_run = 1'b0;
    any_low = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (grant_o[i] == ST_ACTIVE)  any_run = 1'b1;
      if (grant_o[i] >= ST_VOLT_MIN) any_low = 1'b1;
    end
  end

  // R3
  shared_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && any_run) |-> !any_low);

  // R6
  uncore_deep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncore_pd_o |-> (&volt_low_o && !any_run));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_c0 |=> $stable(mode_q));

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      // R4
      wake_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i[g] == ST_ACTIVE) |=> (grant_o[g] == ST_ACTIVE));
      // R7
      volt_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        volt_low_o[g] |-> clk_gate_o[g]);
      // R7
      clk_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_gate_o[g] |-> pipe_stop_o[g]);
    end
  endgenerate
endmodule

bind idle_state_coord idle_state_coord_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .grant_o     (grant_o),
  .pipe_stop_o (pipe_stop_o),
  .clk_gate_o  (clk_gate_o),
  .volt_low_o  (volt_low_o),
  .uncore_pd_o (uncore_pd_o),
  .mode_q      (mode_q),
  .all_c0      (all_c0)
);

// File: tb/idle_state_coord_tb.sv
module idle_state_coord_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shared_mode = 1'b1;
  logic [N-1:0][2:0] req = '0;
  logic [N-1:0][2:0] grant;
  logic [N-1:0] pipe, cgate, vlow;
  logic upd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  idle_state_coord #(.NUM_CORES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .shared_mode_i(shared_mode), .req_i(req),
    .grant_o(grant), .pipe_stop_o(pipe), .clk_gate_o(cgate),
    .volt_low_o(vlow), .uncore_pd_o(upd)
  );

  // behavioural reference
  int exp_g[N];
  string exp_tag[N];
  int m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin exp_g[i] = 0; exp_tag[i] = "R8"; end
      m_mode = 1;
    end else begin
      int r[N];
      bit idle0, running;
      idle0 = 1'b1;
      running = 1'b0;
      for (int i = 0; i < N; i++) if (exp_g[i] != 0) idle0 = 1'b0;
      if (idle0) m_mode = shared_mode;
      for (int i = 0; i < N; i++) begin
        r[i] = (int'(req[i]) > 6) ? 6 : int'(req[i]);
        if (r[i] == 0) running = 1'b1;
      end
      for (int i = 0; i < N; i++) begin
        if (req[i] == 3'd7) exp_tag[i] = "R1";
        else if (r[i] == 0) exp_tag[i] = "R4";
        else if (m_mode == 0) exp_tag[i] = "R5";
        else if (running) exp_tag[i] = "R3";
        else exp_tag[i] = "R2";
        exp_g[i] = (m_mode == 1 && running && r[i] > 3) ? 3 : r[i];
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    bit all6;
    all6 = 1'b1;
    for (int i = 0; i < N; i++) begin
      int e;
      e = exp_g[i];
      if (e != 6) all6 = 1'b0;
      check(int'(grant[i]) == e, exp_tag[i], int'(grant[i]), e);
      check({pipe[i], cgate[i], vlow[i]} == {e >= 1, e >= 3, e >= 4}, "R7",
            int'({pipe[i], cgate[i], vlow[i]}), int'({e >= 1, e >= 3, e >= 4}));
    end
    check(upd == all6, "R6", int'(upd), int'(all6));
  end

  task automatic apply(bit m, int r0, int r1, int r2, int r3);
    shared_mode = m;
    req[0] = 3'(r0); req[1] = 3'(r1); req[2] = 3'(r2); req[3] = 3'(r3);
    @(negedge clk);
  endtask

  task automatic expect_g(string tag, int e0, int e1, int e2, int e3);
    int e[N];
    e = '{e0, e1, e2, e3};
    #1;
    for (int i = 0; i < N; i++) check(int'(grant[i]) == e[i], tag, int'(grant[i]), e[i]);
  endtask

  initial begin
    #45;
    // R8 reset state
    check(grant == '0, "R8", int'(grant), 0);
    check({pipe, cgate, vlow} == '0, "R8", int'({pipe, cgate, vlow}), 0);
    check(upd == 1'b0, "R8", int'(upd), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(1, 0, 6, 6, 6);  expect_g("R3", 0, 3, 3, 3);
    apply(1, 6, 6, 6, 6);  expect_g("R2", 6, 6, 6, 6);
    check(upd == 1'b1, "R6", int'(upd), 1);
    apply(1, 0, 6, 6, 6);  expect_g("R4", 0, 3, 3, 3);
    check(upd == 1'b0, "R6", int'(upd), 0);
    apply(1, 3, 6, 1, 7);  expect_g("R1", 3, 6, 1, 6);
    // mode change while cores asleep is ignored
    apply(0, 0, 6, 5, 4);  expect_g("R9", 0, 3, 3, 3);
    apply(0, 0, 0, 0, 0);  expect_g("R9", 0, 0, 0, 0);
    apply(0, 0, 6, 5, 7);  expect_g("R5", 0, 6, 5, 6);
    apply(1, 0, 6, 4, 0);  expect_g("R9", 0, 6, 4, 0);
    apply(1, 0, 0, 0, 0);  expect_g("R4", 0, 0, 0, 0);
    apply(1, 0, 5, 4, 2);  expect_g("R3", 0, 3, 3, 2);
    for (int k = 0; k < 3000; k++) begin
      bit m;
      m = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) apply(m, 0, 0, 0, 0);
      else apply(m, $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(0, 7));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule